// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Sensing

This block is a register-mapped general-purpose I/O controller for up to twelve pins. Software drives pins through an output-data word and a direction word, reads the pin levels through a two-flop synchronizer, and configures a per-pin interrupt detector. Each detector has a sense mode (falling, rising, either edge, low level or high level), an enable bit, a mask bit and a sticky status bit.

Status bits are cleared by writing 1. A single interrupt line is the OR of all pending, unmasked status bits. A reset word lets software hold the whole configuration at its defaults and then release it.

The register bus is a plain single-cycle access port. A write takes effect on the clock edge where `bus_sel` and `bus_we` are high. Read data is combinational from the selected word and is zero while `bus_sel` is low. There is no back-pressure, because every access completes in its own cycle. Word offsets, as byte addresses:

| Offset | Word | Access |
|---|---|---|
| 0x00 | interrupt enable | read/write |
| 0x04 | raw status | read only |
| 0x08 | masked status | read only |
| 0x0C | status clear | write 1 to clear, reads 0 |
| 0x10 | mask set | write 1 to set, reads the mask |
| 0x14 | mask clear | write 1 to clear, reads the mask |
| 0x18 | output data | read/write |
| 0x1C | input data | read only |
| 0x20 | direction | read/write |
| 0x24 | mode for pins 0 to 7 | read/write |
| 0x28 | mode for pins 8 and up | read/write |
| 0x3C | soft reset | read/write |

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After `rst_n` is released, every mask bit reads 1, and the enable, status, output, direction, both mode words and the reset word all read 0. `irq_o`, `pin_o` and `pin_oe` are 0.
- R2: `pin_oe` equals the direction word (1 means output) and `pin_o` equals the output-data word. The input word at 0x1C shows `pin_i` two clock edges after it is sampled.
- R3: Pin p has a 3-bit mode field at bits 4*(p mod 8)+2 down to 4*(p mod 8). Pins 0 to 7 use the word at 0x24 and pins 8 and up use the word at 0x28. All other bits of these words read 0.
- R4: Mode code 0 sets status on a falling edge, code 1 on a rising edge and code 4 on either edge. The status bit appears on the third rising clock edge after the pin changes.
- R5: Mode code 2 sets status on every cycle the pin reads low, and code 3 on every cycle it reads high. While that level holds, a clear does not leave the bit at 0.
- R6: A status bit is set only while its enable bit (at 0x00) is 1. A bit that is already set stays set when its enable bit is cleared.
- R7: Writing 1 to a bit at 0x10 sets that mask bit, and writing 1 at 0x14 clears it. Zero bits leave the mask unchanged.
- R8: Writing 1 to a bit at 0x0C clears that status bit. If a detected event hits the same bit in the same cycle, the bit stays set.
- R9: `irq_o` is 1 exactly when some status bit is 1 and its mask bit is 0. The word at 0x08 reads status AND NOT mask, and the word at 0x04 reads the raw status.
- R10: Register bits at or above the pin count read 0 and writes to them are ignored. The unused offsets 0x2C to 0x38 read 0. Mode codes 5 to 7 never set status.
- R11: Writing 1 to bit 0 of 0x3C holds every configuration register and status bit at its R1 value and ignores other writes. Writing 0 releases the block. The word reads back bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte address bits 5 to 2 (word index) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| pin_i | input | N_PINS | Asynchronous pin levels |
| pin_o | output | N_PINS | Output data to pads |
| pin_oe | output | N_PINS | Output enable to pads |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default of twelve pins. That makes the upper mode word live, with four fields at pins 8 to 11. It also leaves bits 12 to 31 of every per-pin word free to probe the ignore-and-read-zero rule. The behavioural model runs every sense mode side by side on neighbouring pins, including the inactive codes 5 and 7. It therefore reaches enable gating, the event-beats-clear collision and the soft-reset hold under both directed and pseudo-random pin activity.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int REG_W        = 32;
  localparam int ADDR_W       = 6;
  localparam int WORD_IDX_W   = ADDR_W - 2;
  localparam int MODE_W       = 3;
  localparam int FIELD_STRIDE = 4;
  localparam int LANES        = REG_W / FIELD_STRIDE;

  typedef enum logic [MODE_W-1:0] {
    SENSE_FALL = 3'd0,
    SENSE_RISE = 3'd1,
    SENSE_LOW  = 3'd2,
    SENSE_HIGH = 3'd3,
    SENSE_BOTH = 3'd4
  } sense_e;

  localparam logic [WORD_IDX_W-1:0] W_EN      = 4'd0;
  localparam logic [WORD_IDX_W-1:0] W_STAT    = 4'd1;
  localparam logic [WORD_IDX_W-1:0] W_DISP    = 4'd2;
  localparam logic [WORD_IDX_W-1:0] W_CLR     = 4'd3;
  localparam logic [WORD_IDX_W-1:0] W_MSET    = 4'd4;
  localparam logic [WORD_IDX_W-1:0] W_MCLR    = 4'd5;
  localparam logic [WORD_IDX_W-1:0] W_OUT     = 4'd6;
  localparam logic [WORD_IDX_W-1:0] W_IN      = 4'd7;
  localparam logic [WORD_IDX_W-1:0] W_DIR     = 4'd8;
  localparam logic [WORD_IDX_W-1:0] W_MODE_LO = 4'd9;
  localparam logic [WORD_IDX_W-1:0] W_MODE_HI = 4'd10;
  localparam logic [WORD_IDX_W-1:0] W_SRST    = 4'd15;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_sense_unit.sv
`timescale 1ns/1ps
module gpio_sense_unit
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              cur_i,
  input  logic              prev_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              en_i,
  input  logic              clr_i,
  output logic              stat_o
);
  logic hit;
  logic stat_q;

  always_comb begin
    case (mode_i)
      SENSE_FALL: hit = prev_i & ~cur_i;
      SENSE_RISE: hit = cur_i & ~prev_i;
      SENSE_LOW:  hit = ~cur_i;
      SENSE_HIGH: hit = cur_i;
      SENSE_BOTH: hit = cur_i ^ prev_i;
      default:    hit = 1'b0;
    endcase
  end

  // event has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               stat_q <= 1'b0;
    else if (flush_i)         stat_q <= 1'b0;
    else if (en_i && hit)     stat_q <= 1'b1;
    else if (clr_i)           stat_q <= 1'b0;
  end

  assign stat_o = stat_q;

  p_no_set_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q && !en_i) |=> !stat_q);

  p_clear_when_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !en_i && !flush_i) |=> !stat_q);

  p_level_refires_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !flush_i && mode_i == SENSE_HIGH && cur_i) |=> stat_q);
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:2]     bus_addr,
  input  logic [REG_W-1:0]      bus_wdata,
  output logic [REG_W-1:0]      bus_rdata,
  input  logic [N_PINS-1:0]     pin_i,
  output logic [N_PINS-1:0]     pin_o,
  output logic [N_PINS-1:0]     pin_oe,
  output logic                  irq_o
);
  localparam int MODE_BITS = MODE_W * N_PINS;

  logic                  wr;
  logic [N_PINS-1:0]     wbits;
  logic [N_PINS-1:0]     en_q, mask_q, out_q, dir_q;
  logic [MODE_BITS-1:0]  mode_q;
  logic                  srst_q;
  logic [N_PINS-1:0]     clr_v, stat, sync_cur, sync_prev;
  logic [REG_W-1:0]      rd;
  logic                  unused_wbits;

  assign wr           = bus_sel && bus_we;
  assign wbits        = bus_wdata[N_PINS-1:0];
  assign unused_wbits = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '1;
      out_q  <= '0;
      dir_q  <= '0;
      mode_q <= '0;
      srst_q <= 1'b0;
    end else begin
      if (wr && bus_addr == W_SRST) srst_q <= bus_wdata[0];
      if (srst_q) begin
        en_q   <= '0;
        mask_q <= '1;
        out_q  <= '0;
        dir_q  <= '0;
        mode_q <= '0;
      end else if (wr) begin
        case (bus_addr)
          W_EN:   en_q   <= wbits;
          W_MSET: mask_q <= mask_q | wbits;
          W_MCLR: mask_q <= mask_q & ~wbits;
          W_OUT:  out_q  <= wbits;
          W_DIR:  dir_q  <= wbits;
          W_MODE_LO:
            for (int p = 0; p < N_PINS; p++)
              if (p < LANES)
                mode_q[MODE_W*p +: MODE_W] <= bus_wdata[(p % LANES)*FIELD_STRIDE +: MODE_W];
          W_MODE_HI:
            for (int p = 0; p < N_PINS; p++)
              if (p >= LANES)
                mode_q[MODE_W*p +: MODE_W] <= bus_wdata[(p % LANES)*FIELD_STRIDE +: MODE_W];
          default: ;
        endcase
      end
    end
  end

  assign clr_v = (wr && !srst_q && bus_addr == W_CLR) ? wbits : '0;

  gpio_in_sync #(.W(N_PINS)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .cur_o  (sync_cur),
    .prev_o (sync_prev)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    gpio_sense_unit sense_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (srst_q),
      .cur_i   (sync_cur[g]),
      .prev_i  (sync_prev[g]),
      .mode_i  (mode_q[MODE_W*g +: MODE_W]),
      .en_i    (en_q[g]),
      .clr_i   (clr_v[g]),
      .stat_o  (stat[g])
    );
  end

  always_comb begin
    rd = '0;
    case (bus_addr)
      W_EN:           rd[N_PINS-1:0] = en_q;
      W_STAT:         rd[N_PINS-1:0] = stat;
      W_DISP:         rd[N_PINS-1:0] = stat & ~mask_q;
      W_MSET, W_MCLR: rd[N_PINS-1:0] = mask_q;
      W_OUT:          rd[N_PINS-1:0] = out_q;
      W_IN:           rd[N_PINS-1:0] = sync_cur;
      W_DIR:          rd[N_PINS-1:0] = dir_q;
      W_MODE_LO:
        for (int p = 0; p < N_PINS; p++)
          if (p < LANES)
            rd[(p % LANES)*FIELD_STRIDE +: MODE_W] = mode_q[MODE_W*p +: MODE_W];
      W_MODE_HI:
        for (int p = 0; p < N_PINS; p++)
          if (p >= LANES)
            rd[(p % LANES)*FIELD_STRIDE +: MODE_W] = mode_q[MODE_W*p +: MODE_W];
      W_SRST:         rd[0] = srst_q;
      default: ;
    endcase
  end

  assign bus_rdata = bus_sel ? rd : '0;
  assign irq_o     = |(stat & ~mask_q);
  assign pin_o     = out_q;
  assign pin_oe    = dir_q;

  p_srst_holds_defaults_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (mask_q == '1 && en_q == '0 && dir_q == '0 && out_q == '0 && stat == '0));

  p_mask_set_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !srst_q && bus_addr == W_MSET) |=> ((mask_q & $past(wbits)) == $past(wbits)));
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
  localparam int N = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0]      baddr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [N-1:0]    pins = '0;
  logic [N-1:0]    pin_o, pin_oe;
  logic            irq_o;

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.N_PINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(baddr[5:2]), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_i(pins), .pin_o(pin_o), .pin_oe(pin_oe), .irq_o(irq_o)
  );

  // behavioural reference model
  bit [N-1:0] m_en, m_mask, m_out, m_dir, m_stat, m_s1, m_s2, m_s3;
  int         m_mode [N];
  bit         m_srst;
  int         vecs = 0, errs = 0;
  string      cur_req = "R1";
  bit         done = 0;

  function automatic bit sense(int md, bit now, bit was);
    case (md)
      0: return was && !now;
      1: return now && !was;
      2: return !now;
      3: return now;
      4: return now != was;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = '0; m_mask = '1; m_out = '0; m_dir = '0; m_stat = '0;
      m_s1 = '0; m_s2 = '0; m_s3 = '0; m_srst = 0;
      for (int i = 0; i < N; i++) m_mode[i] = 0;
    end else begin
      bit wr;
      int w;
      wr = bus_sel && bus_we;
      w  = int'(baddr) / 4;
      for (int i = 0; i < N; i++) begin
        if (m_srst) m_stat[i] = 0;
        else if (m_en[i] && sense(m_mode[i], m_s2[i], m_s3[i])) m_stat[i] = 1;
        else if (wr && w == 3 && bus_wdata[i]) m_stat[i] = 0;
      end
      if (m_srst) begin
        m_en = '0; m_mask = '1; m_out = '0; m_dir = '0;
        for (int i = 0; i < N; i++) m_mode[i] = 0;
      end else if (wr) begin
        for (int i = 0; i < N; i++) begin
          case (w)
            0: m_en[i] = bus_wdata[i];
            4: if (bus_wdata[i]) m_mask[i] = 1;
            5: if (bus_wdata[i]) m_mask[i] = 0;
            6: m_out[i] = bus_wdata[i];
            8: m_dir[i] = bus_wdata[i];
            9:  if (i < 8)  m_mode[i] = int'(bus_wdata[4*i +: 3]);
            10: if (i >= 8) m_mode[i] = int'(bus_wdata[4*(i-8) +: 3]);
            default: ;
          endcase
        end
      end
      if (wr && w == 15) m_srst = bus_wdata[0];
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pins;
    end
  end

  function automatic logic [31:0] exp_rd(int w);
    logic [31:0] r;
    r = '0;
    case (w)
      0: r[N-1:0] = m_en;
      1: r[N-1:0] = m_stat;
      2: r[N-1:0] = m_stat & ~m_mask;
      4, 5: r[N-1:0] = m_mask;
      6: r[N-1:0] = m_out;
      7: r[N-1:0] = m_s2;
      8: r[N-1:0] = m_dir;
      9:  for (int i = 0; i < N && i < 8; i++) r[4*i +: 3] = 3'(m_mode[i]);
      10: for (int i = 8; i < N; i++) r[4*(i-8) +: 3] = 3'(m_mode[i]);
      15: r[0] = m_srst;
      default: ;
    endcase
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vecs++;
      if (irq_o !== |(m_stat & ~m_mask)) begin
        errs++; $display("FAIL %s irq_o act=%b exp=%b", cur_req, irq_o, |(m_stat & ~m_mask));
      end
      if (pin_o !== m_out || pin_oe !== m_dir) begin
        errs++; $display("FAIL %s R2 pins act=%h/%h exp=%h/%h", cur_req, pin_o, pin_oe, m_out, m_dir);
      end
      if (bus_sel && !bus_we && bus_rdata !== exp_rd(int'(baddr) / 4)) begin
        errs++; $display("FAIL %s read @%h act=%h exp=%h", cur_req, baddr, bus_rdata, exp_rd(int'(baddr) / 4));
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_we = 1; baddr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a);
    @(posedge clk); #1;
    bus_sel = 1; bus_we = 0; baddr = a;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic setpins(input logic [N-1:0] v, input int hold);
    @(posedge clk); #1; pins = v;
    repeat (hold) @(posedge clk);
  endtask

  task automatic read_all();
    for (int w = 0; w < 16; w++) rd(6'(w * 4));
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    bit [15:0] lf;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cur_req = "R1"; read_all();
    cur_req = "R2";
    wr(6'h20, 32'h0000_0A5A); wr(6'h18, 32'h0000_03C3);
    rd(6'h20); rd(6'h18);
    setpins(12'h5A5, 1); rd(6'h1C); rd(6'h1C); rd(6'h1C);
    cur_req = "R3";
    wr(6'h24, 32'hFFFF_FFFF); rd(6'h24);
    wr(6'h28, 32'hFFFF_FFFF); rd(6'h28);
    // pin0 fall, 1 rise, 2 low, 3 high, 4 both, 5 code5, 6 code7, 7 rise
    wr(6'h24, 32'h1754_3210); rd(6'h24);
    wr(6'h28, 32'h0000_3241); rd(6'h28);
    wr(6'h0C, 32'h0000_0FFF);
    cur_req = "R4";
    wr(6'h00, 32'h0000_0FFF);
    wr(6'h14, 32'h0000_0FFF);
    setpins(12'h000, 4); rd(6'h04); wr(6'h0C, 32'h0000_0FFF);
    setpins(12'hFFF, 1); rd(6'h04); rd(6'h04); rd(6'h04);
    setpins(12'h000, 4); rd(6'h04);
    cur_req = "R5";
    setpins(12'h008, 4);
    wr(6'h0C, 32'h0000_0FFF); rd(6'h04); rd(6'h04);
    cur_req = "R8";
    wr(6'h0C, 32'h0000_0FFF); setpins(12'h000, 4); wr(6'h0C, 32'h0000_0FFF); rd(6'h04);
    cur_req = "R6";
    wr(6'h00, 32'h0000_00F0); wr(6'h0C, 32'h0000_0FFF);
    setpins(12'hFFF, 4); rd(6'h04); setpins(12'h000, 4); rd(6'h04);
    wr(6'h00, 32'h0000_0000); rd(6'h04);
    cur_req = "R7";
    wr(6'h10, 32'h0000_00F0); rd(6'h10); wr(6'h10, 32'h0); rd(6'h10);
    wr(6'h14, 32'h0000_0030); rd(6'h14); wr(6'h14, 32'h0); rd(6'h14);
    cur_req = "R9";
    rd(6'h08); rd(6'h04); wr(6'h14, 32'h0000_0FFF); rd(6'h08);
    wr(6'h10, 32'h0000_0FFF); rd(6'h08);
    cur_req = "R10";
    wr(6'h00, 32'hFFFF_FFFF); wr(6'h18, 32'hFFFF_F000); wr(6'h20, 32'hFFFF_FFFF);
    for (int w = 0; w < 16; w++) rd(6'(w * 4));
    wr(6'h14, 32'h0000_0FFF); wr(6'h0C, 32'h0000_0FFF);
    for (int k = 0; k < 6; k++) setpins(12'(k[0] ? 12'h060 : 12'h000), 3);
    rd(6'h04);
    cur_req = "R4";
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[0] && lf[5]) wr(6'h0C, {20'd0, lf[15:4]});
      else if (lf[1] && lf[6]) wr(6'h10, {28'd0, lf[11:8]} << 4);
      else if (lf[2] && lf[7]) wr(6'h14, {20'd0, lf[14:3]});
      else if (lf[3]) rd(6'h04);
      else setpins(lf[13:2], 1);
    end
    cur_req = "R11";
    wr(6'h3C, 32'h1); rd(6'h3C);
    wr(6'h00, 32'h0000_0FFF); wr(6'h14, 32'h0000_0FFF);
    setpins(12'hFFF, 4); read_all();
    wr(6'h3C, 32'h0); read_all();
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule